// File: doc/BRIEF.md
# Serial Gain Control Register

This block is the slave side of a three-wire control port that sets the gain code of a programmable line amplifier. A host starts a transfer by pulling an active-low frame enable low, then clocks a gain word onto a serial data line one bit per rising edge of a serial clock, most significant bit first. The port keeps only the last seven bits it sampled. A normal transfer carries eight bits, so the first bit it receives is pushed out and has no effect on the result.

When the frame enable returns high, the seven held bits move to the parallel gain output as one step. At the same moment the block sets a flag that tells whether the code lies in the monotonic range, and it gives a one-cycle update strobe. The code is also split into a coarse attenuation field and a fine vernier field. In the range above the valid codes, the vernier field repeats every eight codes.

All three serial inputs are synchronized into a faster system clock and their edges are found in that domain. The serial clock must run at no more than a quarter of the system clock rate. A sticky flag reports a transfer that carried any bit count other than eight.

Top module: `sgain_port`

## Requirements
- R1: A falling edge of the frame enable starts a frame. It clears the seven-bit shift register and the bit counter. Serial clock edges are sampled only while the frame enable is low.
- R2: On each rising serial clock edge inside a frame, the data bit enters the least significant end of the shift register and the older bits move up. After eight bits, the code is the last seven bits (word bits 6..0), so words 0x80..0xFF give the same code as 0x00..0x7F.
- R3: The gain code output changes only on a rising edge of the frame enable. Serial activity while no frame is open, and the bits sampled during a frame, leave it unchanged.
- R4: The valid flag is 1 when the latched code is 79 or less and 0 for codes 80..127. It is updated together with the gain code.
- R5: The coarse field equals code bits 6..3 and the vernier field equals code bits 2..0.
- R6: The error flag is set at the end of a frame that carried a bit count other than eight. The last seven sampled bits are still latched, with zeros filling the places not written in that frame. The flag stays set until the next frame starts, which clears it.
- R7: Each frame end gives exactly one update strobe, one system clock cycle wide. Serial clock activity outside a frame gives none.
- R8: After reset the gain code is 0, the valid flag is 1, and the error flag and the update strobe are 0.
- R9: A rising serial clock edge seen in the same system cycle as the frame start counts as the first bit of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_n_i | input | 1 | Active-low frame enable (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdat_i | input | 1 | Serial data, sampled on serial clock rise |
| gain_code_o | output | 7 | Latched gain code |
| coarse_o | output | 4 | Coarse attenuation field, code bits 6..3 |
| vernier_o | output | 3 | Fine vernier field, code bits 2..0 |
| code_ok_o | output | 1 | Latched code is within 0..79 |
| count_err_o | output | 1 | Sticky: last frame had a bit count other than eight |
| update_o | output | 1 | One-cycle strobe when the gain output is loaded |

## Verification
Two events can land in the same system cycle: the frame start, which clears the bit counter, and the first sampled serial clock rise, which advances it. The bench provokes this by driving the frame enable low and the serial clock high on the same edge. Both pass through synchronizers of equal depth, so the design sees them together. The test is judged by sending exactly eight bits this way and checking that the code is right and the error flag stays clear. A design that dropped the overlapping bit would latch a shifted code and report a count of seven.

// File: rtl/sgain_pkg.sv
// Package: shared widths and limits for the serial gain control port.
// Assumes a seven-bit code split into a coarse field and a vernier field.
package sgain_pkg;
    localparam int CODE_W    = 7;   // bits held by the shift register
    localparam int VERN_W    = 3;   // fine vernier field width
    localparam int WORD_BITS = 8;   // bits in a well-formed frame
    localparam int MAX_CODE  = 79;  // highest code of the monotonic range
    localparam int SYNC_N    = 2;   // synchronizer depth

    // Latched result of one frame
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ok;
        logic              err;
    } gain_rec_t;
endpackage

// File: rtl/sgain_sync.sv
// Module: multi-bit flop chain that brings asynchronous inputs into clk.
// Assumes each bit is independent; no bus coherency is provided.
module sgain_sync #(
    parameter int               W      = 3,
    parameter int               STAGES = 2,
    parameter logic [W-1:0]     RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    if (STAGES == 1) begin : g_one
        // Single stage register
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= RST_V;
            else        chain <= din;
        end
    end else begin : g_many
        // Shift the input through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_V}};
            else        chain <= {chain[CHAIN_W-W-1:0], din};
        end
    end

    assign dout = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sgain_shift.sv
// Module: seven-bit serial shift register with a saturating bit counter.
// Assumes start and sample are single-cycle pulses in the clk domain;
// a start that coincides with a sample keeps that sample as bit one.
module sgain_shift #(
    parameter int CODE_W = sgain_pkg::CODE_W,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sample,
    input  logic              bit_in,
    output logic [CODE_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Shift in the serial bit, clearing the register at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (start) begin
            shreg <= sample ? {{(CODE_W-1){1'b0}}, bit_in} : '0;
        end else if (sample) begin
            shreg <= {shreg[CODE_W-2:0], bit_in};
        end
    end

    // Count sampled bits, saturating so long frames never wrap to eight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (start) begin
            bit_cnt <= sample ? CNT_W'(1) : '0;
        end else if (sample && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sgain_latch.sv
// Module: output register loaded at frame end, with range check, field
// split, sticky bit-count error and update strobe.
// Assumes start and finish never occur in the same cycle.
module sgain_latch #(
    parameter int CODE_W    = sgain_pkg::CODE_W,
    parameter int VERN_W    = sgain_pkg::VERN_W,
    parameter int WORD_BITS = sgain_pkg::WORD_BITS,
    parameter int MAX_CODE  = sgain_pkg::MAX_CODE,
    parameter int CNT_W     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     finish,
    input  logic [CODE_W-1:0]        shreg,
    input  logic [CNT_W-1:0]         bit_cnt,
    output logic [CODE_W-1:0]        code,
    output logic [CODE_W-VERN_W-1:0] coarse,
    output logic [VERN_W-1:0]        vern,
    output logic                     ok,
    output logic                     err,
    output logic                     upd
);
    import sgain_pkg::*;

    localparam logic [CODE_W-1:0] LIMIT    = CODE_W'(MAX_CODE);
    localparam logic [CNT_W-1:0]  GOOD_CNT = CNT_W'(WORD_BITS);

    gain_rec_t nxt;
    gain_rec_t cur;

    // Form the record that a frame end would load
    always_comb begin
        nxt.code = shreg;
        nxt.ok   = (shreg <= LIMIT);
        nxt.err  = (bit_cnt != GOOD_CNT);
    end

    // Load the record at frame end; clear the error at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '{code: '0, ok: 1'b1, err: 1'b0};
        end else if (finish) begin
            cur <= nxt;
        end else if (start) begin
            cur.err <= 1'b0;
        end
    end

    // One-cycle strobe marking a load
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= finish;
    end

    assign code   = cur.code;
    assign ok     = cur.ok;
    assign err    = cur.err;
    assign coarse = cur.code[CODE_W-1:VERN_W];
    assign vern   = cur.code[VERN_W-1:0];
endmodule

// File: rtl/sgain_port.sv
// Module: serial gain control port, top level.
// Synchronizes the three serial inputs into clk, finds frame and clock
// edges, shifts data and latches the gain code when the frame ends.
// Assumes the serial clock runs at no more than a quarter of clk.
module sgain_port #(
    parameter int CODE_W    = sgain_pkg::CODE_W,
    parameter int VERN_W    = sgain_pkg::VERN_W,
    parameter int WORD_BITS = sgain_pkg::WORD_BITS,
    parameter int MAX_CODE  = sgain_pkg::MAX_CODE,
    parameter int SYNC_N    = sgain_pkg::SYNC_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_n_i,
    input  logic                     sclk_i,
    input  logic                     sdat_i,
    output logic [CODE_W-1:0]        gain_code_o,
    output logic [CODE_W-VERN_W-1:0] coarse_o,
    output logic [VERN_W-1:0]        vernier_o,
    output logic                     code_ok_o,
    output logic                     count_err_o,
    output logic                     update_o
);
    localparam int CNT_W = $clog2(2 * WORD_BITS + 1);

    logic [2:0]       sync_q;
    logic             frm_s, sclk_s, dat_s;
    logic [1:0]       prev_q;
    logic             frm_fall, frm_rise, sclk_rise;
    logic [CODE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    sgain_sync #(
        .W      (3),
        .STAGES (SYNC_N),
        .RST_V  (3'b100)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({frm_n_i, sclk_i, sdat_i}),
        .dout  (sync_q)
    );

    assign {frm_s, sclk_s, dat_s} = sync_q;

    // Remember last synchronized frame and clock levels for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b10;
        else        prev_q <= {frm_s, sclk_s};
    end

    assign frm_fall  = prev_q[1] & ~frm_s;
    assign frm_rise  = ~prev_q[1] & frm_s;
    assign sclk_rise = sclk_s & ~prev_q[0] & ~frm_s;

    sgain_shift #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frm_fall),
        .sample  (sclk_rise),
        .bit_in  (dat_s),
        .shreg   (shreg),
        .bit_cnt (bit_cnt)
    );

    sgain_latch #(
        .CODE_W    (CODE_W),
        .VERN_W    (VERN_W),
        .WORD_BITS (WORD_BITS),
        .MAX_CODE  (MAX_CODE),
        .CNT_W     (CNT_W)
    ) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frm_fall),
        .finish  (frm_rise),
        .shreg   (shreg),
        .bit_cnt (bit_cnt),
        .code    (gain_code_o),
        .coarse  (coarse_o),
        .vern    (vernier_o),
        .ok      (code_ok_o),
        .err     (count_err_o),
        .upd     (update_o)
    );
endmodule

// File: rtl/sgain_port_chk.sv
// Checker: temporal properties of the serial gain control port.
// Bound to every sgain_port instance.
module sgain_port_chk #(
    parameter int CODE_W   = 7,
    parameter int MAX_CODE = 79
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_fall,
    input logic              frm_rise,
    input logic [CODE_W-1:0] gain_code_o,
    input logic              code_ok_o,
    input logic              count_err_o,
    input logic              update_o
);
    // R3: the code moves only with the update strobe
    a_r3_code_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code_o != $past(gain_code_o)) |-> update_o);

    // R4: valid flag agrees with the loaded code
    a_r4_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (code_ok_o == (gain_code_o <= CODE_W'(MAX_CODE))));

    // R6: frame start clears the sticky error
    a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frm_fall |=> !count_err_o);

    // R7: strobe follows a frame end and lasts one cycle
    a_r7_strobe_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rise |=> update_o);

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);
endmodule

bind sgain_port sgain_port_chk #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
) i_sgain_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_fall    (frm_fall),
    .frm_rise    (frm_rise),
    .gain_code_o (gain_code_o),
    .code_ok_o   (code_ok_o),
    .count_err_o (count_err_o),
    .update_o    (update_o)
);

// File: tb/test_sgain_port.sv
// Bench: table-driven frames followed by directed reset and corner tests.
module test_sgain_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic [6:0] gain_code;
    logic [3:0] coarse;
    logic [2:0] vern;
    logic       code_ok, count_err, update;

    int checks = 0;
    int errors = 0;
    int upd_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    sgain_port i_sgain_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_n_i     (frm_n),
        .sclk_i      (sclk),
        .sdat_i      (sdat),
        .gain_code_o (gain_code),
        .coarse_o    (coarse),
        .vernier_o   (vern),
        .code_ok_o   (code_ok),
        .count_err_o (count_err),
        .update_o    (update)
    );

    // Count strobe cycles away from the active edge
    always @(negedge clk) if (rst_n && update) upd_seen++;

    // Vector: {bit count, word (sent low nbits, MSB first), expected code}
    localparam int NV = 11;
    localparam logic [22:0] VEC [NV] = '{
        {4'd8,  12'h000, 7'd0},
        {4'd8,  12'h04F, 7'd79},
        {4'd8,  12'h050, 7'd80},
        {4'd8,  12'h0CF, 7'd79},
        {4'd8,  12'h07F, 7'd127},
        {4'd8,  12'h0A5, 7'd37},
        {4'd5,  12'h016, 7'd22},
        {4'd10, 12'h2A5, 7'd37},
        {4'd7,  12'h04F, 7'd79},
        {4'd0,  12'h000, 7'd0},
        {4'd8,  12'h033, 7'd51}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Open a frame and send nbits of word, MSB first; simult merges the
    // first clock rise with the frame start
    task automatic frame_body(int nbits, logic [11:0] word, bit simult);
        @(negedge clk);
        frm_n = 1'b0;
        if (simult && nbits > 0) begin
            sdat = word[nbits-1];
            sclk = 1'b1;
            cycles(4);
            sclk = 1'b0;
        end
        cycles(4);
        for (int i = nbits - 1 - ((simult && nbits > 0) ? 1 : 0); i >= 0; i--) begin
            sdat = word[i];
            cycles(4);
            sclk = 1'b1;
            cycles(4);
            sclk = 1'b0;
        end
        cycles(4);
    endtask

    task automatic frame_end();
        frm_n = 1'b1;
        cycles(8);
    endtask

    task automatic check_result(logic [6:0] exp_code, bit exp_err, string tag);
        check({"R2 code ", tag}, gain_code, exp_code);
        check({"R4 ok ", tag}, code_ok, (exp_code <= 7'd79) ? 1 : 0);
        check({"R5 coarse ", tag}, coarse, exp_code[6:3]);
        check({"R5 vernier ", tag}, vern, exp_code[2:0]);
        check({"R6 err ", tag}, count_err, exp_err);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] prev_code;
        int u0;
        cycles(5);
        rst_n = 1'b1;
        cycles(3);
        // R8: reset state
        check("R8 code", gain_code, 0);
        check("R8 ok", code_ok, 1);
        check("R8 err", count_err, 0);
        check("R8 update", upd_seen, 0);

        prev_code = 7'd0;
        for (int v = 0; v < NV; v++) begin
            int          nb;
            logic [11:0] w;
            logic [6:0]  ec;
            {nb, w, ec} = {28'(VEC[v][22:19]), VEC[v][18:7], VEC[v][6:0]};
            u0 = upd_seen;
            frame_body(nb, w, 1'b0);
            // R3: held during the frame; R1/R6: start cleared the error
            check("R3 hold in frame", gain_code, prev_code);
            check("R6 cleared by start", count_err, 0);
            frame_end();
            check_result(ec, (nb != 8), $sformatf("vec%0d", v));
            check("R7 one strobe", upd_seen - u0, 1);
            prev_code = ec;
        end

        // R3/R7: serial clocks with no frame open are ignored
        u0 = upd_seen;
        sdat = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cycles(4);
            sclk = 1'b1;
            cycles(4);
            sclk = 1'b0;
        end
        cycles(8);
        check("R3 ignored outside frame", gain_code, prev_code);
        check("R7 no strobe outside frame", upd_seen - u0, 0);

        // R1: a frame after idle clocking starts from a cleared register
        frame_body(3, 12'h005, 1'b0);
        frame_end();
        check_result(7'd5, 1'b1, "R1 cleared start");

        // R9: first clock rise in the same cycle as the frame start
        u0 = upd_seen;
        frame_body(8, 12'h15A, 1'b1);
        frame_end();
        check_result(7'h5A, 1'b0, "R9 simultaneous");
        check("R9 strobe", upd_seen - u0, 1);

        // R8: reset mid-life returns to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(3);
        check("R8 code after reset", gain_code, 0);
        check("R8 ok after reset", code_ok, 1);
        check("R8 err after reset", count_err, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule